// File: doc/BRIEF.md
# Open-Row-Priority Bank Request Scheduler

This block sits in front of a single DRAM bank and decides which pending read goes to the bank next. Incoming reads arrive over a valid/ready handshake, each tagged with a thread number, a row and a 7-bit column (a row of 8 KB split into 64-byte blocks gives 128 columns). Up to eight reads wait in a small buffer. The block keeps track of which row the bank currently holds open. Whenever the bank is free, it sends it one read, choosing by two rules. A read that targets the open row always goes first. Among reads that are equally placed, the one that arrived earliest goes first.

Every read is classified when it is issued. It is a hit if its row is already open, an empty access if no row is open yet, and a conflict if a different row is open. Service time is a fixed number of cycles for each class. When service ends, the block reports the read's thread, row, column and class in a one-cycle completion pulse. After an access the accessed row stays open, so later reads to it are served as hits.

Top module: `rowhit_sched`

## Requirements
- R1: After reset, req_ready is 1, done_valid is 0 and no row is open, so the first read issued after reset completes with class code 01 (empty).
- R2: The buffer holds 8 pending reads. req_ready is 0 exactly while 8 reads are pending. A read offered while req_ready is 0 is dropped and never completes.
- R3: done_kind encodes the class decided at issue time: 00 when the read's row equals the open row, 01 when no row is open, 10 when a different row is open. The code 11 never appears.
- R4: Whenever at least one pending read targets the open row, the next read issued is one of those, even if non-hit reads arrived before it.
- R5: Among pending reads of the same class (hit or non-hit), the one accepted earliest is issued first.
- R6: The row of each issued read becomes the open row and stays open until another row is issued.
- R7: A read leaves the buffer at a clock edge and is then in service for 2 cycles (hit), 4 cycles (empty) or 6 cycles (conflict). done_valid is high in the last of those cycles. The next read leaves the buffer at the edge that ends that cycle, at the earliest.
- R8: At most one read is in service at a time. done_valid is a single-cycle pulse that carries the thread, row and column of the read that was in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A read is offered |
| req_ready | output | 1 | Buffer can take a read this cycle |
| req_tid | input | 2 | Thread number of the offered read |
| req_row | input | 8 | Row of the offered read |
| req_col | input | 7 | Column block of the offered read |
| done_valid | output | 1 | Completion pulse |
| done_tid | output | 2 | Thread number of the completed read |
| done_row | output | 8 | Row of the completed read |
| done_col | output | 7 | Column of the completed read |
| done_kind | output | 2 | Class code: 00 hit, 01 empty, 10 conflict |

## Verification
The hardest case to create is a read to the open row that arrives after older reads to other rows, while the bank is still busy. Only then do the older conflicts and the younger hit wait in the buffer together at the moment of choice. The bench builds this case directly. It first opens a row and then, within that read's service window, queues two conflicting rows followed by a read to the open row. It also runs a long mix of a streaming thread that stays in one row and a thread that picks random rows, offering reads faster than they can be served. This keeps the buffer full and makes hit-bypass decisions happen many times over.

// File: rtl/rhs_pkg.sv
package rhs_pkg;
  typedef enum logic [1:0] {
    KIND_HIT      = 2'b00,
    KIND_EMPTY    = 2'b01,
    KIND_CONFLICT = 2'b10
  } kind_e;
endpackage

// File: rtl/rhs_slots.sv
// Pending-read storage with per-slot arrival rank (0 = oldest).
module rhs_slots #(
  parameter int DEPTH = 8,
  parameter int TID_W = 2,
  parameter int ROW_W = 8,
  parameter int COL_W = 7,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [TID_W-1:0]                  wr_tid,
  input  logic [ROW_W-1:0]                  wr_row,
  input  logic [COL_W-1:0]                  wr_col,
  output logic                              wr_ready,
  input  logic                              clr_en,
  input  logic [IDX_W-1:0]                  clr_idx,
  output logic [DEPTH-1:0]                  slot_vld,
  output logic [DEPTH-1:0][TID_W-1:0]       slot_tid,
  output logic [DEPTH-1:0][ROW_W-1:0]       slot_row,
  output logic [DEPTH-1:0][COL_W-1:0]       slot_col,
  output logic [DEPTH-1:0][IDX_W-1:0]       slot_rank
);
  logic [DEPTH-1:0]            vld_q, vld_d, load;
  logic [DEPTH-1:0][IDX_W-1:0] rank_q, rank_d;
  logic [DEPTH-1:0][TID_W-1:0] tid_q;
  logic [DEPTH-1:0][ROW_W-1:0] row_q;
  logic [DEPTH-1:0][COL_W-1:0] col_q;
  logic [IDX_W:0]              occ, new_rank;
  logic [IDX_W-1:0]            free_idx, clr_rank;
  logic                        accept;

  assign wr_ready = ~&vld_q;
  assign accept   = wr_en & wr_ready;
  assign clr_rank = rank_q[clr_idx];

  always_comb begin
    occ      = '0;
    free_idx = '0;
    for (int i = DEPTH-1; i >= 0; i--) begin
      occ = occ + (IDX_W+1)'(vld_q[i]);
      if (!vld_q[i]) free_idx = IDX_W'(i);
    end
    new_rank = occ - (IDX_W+1)'(clr_en);
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      vld_d[i]  = vld_q[i];
      rank_d[i] = rank_q[i];
      load[i]   = 1'b0;
      if (clr_en && clr_idx == IDX_W'(i)) begin
        vld_d[i] = 1'b0;
      end else if (clr_en && vld_q[i] && rank_q[i] > clr_rank) begin
        rank_d[i] = rank_q[i] - 1'b1;
      end
      if (accept && free_idx == IDX_W'(i)) begin
        vld_d[i]  = 1'b1;
        rank_d[i] = new_rank[IDX_W-1:0];
        load[i]   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      rank_q <= '0;
    end else begin
      vld_q  <= vld_d;
      rank_q <= rank_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_payload
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tid_q[g] <= '0;
        row_q[g] <= '0;
        col_q[g] <= '0;
      end else if (load[g]) begin
        tid_q[g] <= wr_tid;
        row_q[g] <= wr_row;
        col_q[g] <= wr_col;
      end
    end
  end

  assign slot_vld  = vld_q;
  assign slot_tid  = tid_q;
  assign slot_row  = row_q;
  assign slot_col  = col_q;
  assign slot_rank = rank_q;

  AST_FULL_MEANS_EIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> occ == (IDX_W+1)'(DEPTH)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ready && !clr_en) |=> vld_q == $past(vld_q)); // R2
endmodule

// File: rtl/rhs_pick.sv
// Chooses open-row matches first, then the lowest arrival rank.
module rhs_pick #(
  parameter int DEPTH = 8,
  parameter int ROW_W = 8,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]            slot_vld,
  input  logic [DEPTH-1:0][ROW_W-1:0] slot_row,
  input  logic [DEPTH-1:0][IDX_W-1:0] slot_rank,
  input  logic                        open_vld,
  input  logic [ROW_W-1:0]            open_row,
  output logic                        any,
  output logic [IDX_W-1:0]            pick_idx,
  output logic                        pick_hit
);
  logic [IDX_W-1:0] best_rank;
  logic             hit_i;

  always_comb begin
    any       = 1'b0;
    pick_idx  = '0;
    pick_hit  = 1'b0;
    best_rank = '1;
    hit_i     = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      hit_i = slot_vld[i] && open_vld && slot_row[i] == open_row;
      if (slot_vld[i] && (!any || (hit_i && !pick_hit) ||
                          (hit_i == pick_hit && slot_rank[i] < best_rank))) begin
        any       = 1'b1;
        pick_idx  = IDX_W'(i);
        pick_hit  = hit_i;
        best_rank = slot_rank[i];
      end
    end
  end
endmodule

// File: rtl/rhs_engine.sv
// Single-request service timer and open-row tracker.
module rhs_engine
  import rhs_pkg::*;
#(
  parameter int TID_W     = 2,
  parameter int ROW_W     = 8,
  parameter int COL_W     = 7,
  parameter int HIT_CYC   = 2,
  parameter int EMPTY_CYC = 4,
  parameter int CONF_CYC  = 6,
  parameter int CNT_W     = $clog2(CONF_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TID_W-1:0] st_tid,
  input  logic [ROW_W-1:0] st_row,
  input  logic [COL_W-1:0] st_col,
  input  logic             st_hit,
  output logic             busy,
  output logic             open_vld,
  output logic [ROW_W-1:0] open_row,
  output logic             done_vld,
  output logic [TID_W-1:0] done_tid,
  output logic [ROW_W-1:0] done_row,
  output logic [COL_W-1:0] done_col,
  output logic [1:0]       done_kind
);
  logic             busy_q, busy_d, open_vld_q, open_vld_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ROW_W-1:0] open_row_q, open_row_d;
  kind_e            kind_q, kind_d;
  logic [TID_W-1:0] tid_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;

  always_comb begin
    busy_d     = busy_q;
    cnt_d      = cnt_q;
    kind_d     = kind_q;
    open_vld_d = open_vld_q;
    open_row_d = open_row_q;
    if (start) begin
      busy_d     = 1'b1;
      open_vld_d = 1'b1;
      open_row_d = st_row;
      if (!open_vld_q) begin
        kind_d = KIND_EMPTY;
        cnt_d  = CNT_W'(EMPTY_CYC - 1);
      end else if (st_hit) begin
        kind_d = KIND_HIT;
        cnt_d  = CNT_W'(HIT_CYC - 1);
      end else begin
        kind_d = KIND_CONFLICT;
        cnt_d  = CNT_W'(CONF_CYC - 1);
      end
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      kind_q     <= KIND_HIT;
      open_vld_q <= 1'b0;
      open_row_q <= '0;
    end else begin
      busy_q     <= busy_d;
      cnt_q      <= cnt_d;
      kind_q     <= kind_d;
      open_vld_q <= open_vld_d;
      open_row_q <= open_row_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tid_q <= '0;
      row_q <= '0;
      col_q <= '0;
    end else if (start) begin
      tid_q <= st_tid;
      row_q <= st_row;
      col_q <= st_col;
    end
  end

  assign busy      = busy_q;
  assign open_vld  = open_vld_q;
  assign open_row  = open_row_q;
  assign done_vld  = busy_q && cnt_q == '0;
  assign done_tid  = tid_q;
  assign done_row  = row_q;
  assign done_col  = col_q;
  assign done_kind = kind_q;

  AST_ISSUE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_vld |=> !done_vld); // R8
  AST_KIND_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    done_vld |-> done_kind != 2'b11); // R3
  AST_OPEN_ROW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    done_vld |-> (open_vld_q && open_row_q == done_row)); // R6
  AST_HIT_ROW_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st_hit) |-> (open_vld_q && st_row == open_row_q)); // R3
endmodule

// File: rtl/rowhit_sched.sv
module rowhit_sched #(
  parameter int DEPTH     = 8,
  parameter int TID_W     = 2,
  parameter int ROW_W     = 8,
  parameter int COL_W     = 7,
  parameter int HIT_CYC   = 2,
  parameter int EMPTY_CYC = 4,
  parameter int CONF_CYC  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [TID_W-1:0] req_tid,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  output logic             done_valid,
  output logic [TID_W-1:0] done_tid,
  output logic [ROW_W-1:0] done_row,
  output logic [COL_W-1:0] done_col,
  output logic [1:0]       done_kind
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0]            slot_vld;
  logic [DEPTH-1:0][TID_W-1:0] slot_tid;
  logic [DEPTH-1:0][ROW_W-1:0] slot_row;
  logic [DEPTH-1:0][COL_W-1:0] slot_col;
  logic [DEPTH-1:0][IDX_W-1:0] slot_rank;
  logic                        any, pick_hit, busy, open_vld, issue;
  logic [IDX_W-1:0]            pick_idx;
  logic [ROW_W-1:0]            open_row;

  assign issue = any && !busy;

  rhs_slots #(.DEPTH(DEPTH), .TID_W(TID_W), .ROW_W(ROW_W), .COL_W(COL_W),
              .IDX_W(IDX_W)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .wr_en(req_valid), .wr_tid(req_tid), .wr_row(req_row), .wr_col(req_col),
    .wr_ready(req_ready), .clr_en(issue), .clr_idx(pick_idx),
    .slot_vld(slot_vld), .slot_tid(slot_tid), .slot_row(slot_row),
    .slot_col(slot_col), .slot_rank(slot_rank)
  );

  rhs_pick #(.DEPTH(DEPTH), .ROW_W(ROW_W), .IDX_W(IDX_W)) u_pick (
    .slot_vld(slot_vld), .slot_row(slot_row), .slot_rank(slot_rank),
    .open_vld(open_vld), .open_row(open_row),
    .any(any), .pick_idx(pick_idx), .pick_hit(pick_hit)
  );

  rhs_engine #(.TID_W(TID_W), .ROW_W(ROW_W), .COL_W(COL_W),
               .HIT_CYC(HIT_CYC), .EMPTY_CYC(EMPTY_CYC),
               .CONF_CYC(CONF_CYC)) u_engine (
    .clk(clk), .rst_n(rst_n), .start(issue),
    .st_tid(slot_tid[pick_idx]), .st_row(slot_row[pick_idx]),
    .st_col(slot_col[pick_idx]), .st_hit(pick_hit),
    .busy(busy), .open_vld(open_vld), .open_row(open_row),
    .done_vld(done_valid), .done_tid(done_tid), .done_row(done_row),
    .done_col(done_col), .done_kind(done_kind)
  );

  // Independent view of the buffer for the selection checks.
  logic hit_pending, older_peer;
  always_comb begin
    hit_pending = 1'b0;
    older_peer  = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_vld[i] && open_vld && slot_row[i] == open_row) hit_pending = 1'b1;
      if (slot_vld[i] && IDX_W'(i) != pick_idx &&
          ((open_vld && slot_row[i] == open_row) == pick_hit) &&
          slot_rank[i] < slot_rank[pick_idx]) older_peer = 1'b1;
    end
  end

  AST_HIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && hit_pending) |-> pick_hit); // R4
  AST_OLDEST_IN_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !older_peer); // R5
endmodule

// File: tb/tb_rowhit_sched.sv
module tb_rowhit_sched;
  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_tid = '0;
  logic [7:0] req_row = '0;
  logic [6:0] req_col = '0;
  logic       done_valid;
  logic [1:0] done_tid;
  logic [7:0] done_row;
  logic [6:0] done_col;
  logic [1:0] done_kind;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk; // 125 MHz

  rowhit_sched dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_tid(req_tid), .req_row(req_row), .req_col(req_col),
    .done_valid(done_valid), .done_tid(done_tid), .done_row(done_row),
    .done_col(done_col), .done_kind(done_kind)
  );

  // ---------------- behavioural reference ----------------
  typedef struct { int tid; int row; int col; } mreq_t;
  mreq_t mq[$];
  bit    m_busy, m_open_vld;
  int    m_cnt, m_open_row, m_kind;
  mreq_t m_cur;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
      m_busy = 0; m_open_vld = 0; m_cnt = 0; m_open_row = 0; m_kind = 0;
    end else begin
      bit acc;
      acc = req_valid && (mq.size() < DEPTH);
      if (!m_busy && mq.size() > 0) begin
        int sel;
        sel = 0;
        if (m_open_vld)
          foreach (mq[k]) if (mq[k].row == m_open_row) begin sel = k; break; end
        m_cur = mq[sel];
        if (!m_open_vld)                  begin m_kind = 1; m_cnt = 3; end
        else if (m_cur.row == m_open_row) begin m_kind = 0; m_cnt = 1; end
        else                              begin m_kind = 2; m_cnt = 5; end
        mq.delete(sel);
        m_busy = 1; m_open_vld = 1; m_open_row = m_cur.row;
      end else if (m_busy) begin
        if (m_cnt == 0) m_busy = 0; else m_cnt--;
      end
      if (acc) begin
        mreq_t n;
        n.tid = req_tid; n.row = req_row; n.col = req_col;
        mq.push_back(n);
      end
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  int done_log[$];

  always @(negedge clk) begin
    bit md;
    md = m_busy && m_cnt == 0;
    chk(rst_n ? "R2" : "R1", "req_ready", int'(req_ready), int'(mq.size() < DEPTH));
    chk(rst_n ? "R7" : "R1", "done_valid", int'(done_valid), int'(md));
    if (md && done_valid) begin
      chk("R3 R6", "done_kind", int'(done_kind), m_kind);
      chk("R4 R5 R8", "done_tid", int'(done_tid), m_cur.tid);
      chk("R4 R5 R8", "done_row", int'(done_row), m_cur.row);
      chk("R8", "done_col", int'(done_col), m_cur.col);
      done_log.push_back({int'(done_kind), 8'(done_row)});
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input int tid, input int row, input int col);
    @(negedge clk);
    req_valid = 1; req_tid = 2'(tid); req_row = 8'(row); req_col = 7'(col);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic drain();
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (mq.size() == 0 && !m_busy) break;
    end
  endtask

  task automatic run_main();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // r1_: first read after reset sees an empty row buffer
    done_log.delete();
    send(0, 7, 1);
    drain();
    chk("R1", "first kind", done_log.size() > 0 ? done_log[0] >> 8 : -1, 1);
    // r4_ r5_: younger hit bypasses older conflicts queued during service
    done_log.delete();
    send(0, 20, 0);
    send(1, 30, 2);
    send(1, 31, 3);
    send(0, 20, 5);
    drain();
    chk("R4", "2nd row", done_log.size() > 1 ? done_log[1] & 255 : -1, 20);
    chk("R5", "3rd row", done_log.size() > 2 ? done_log[2] & 255 : -1, 30);
    chk("R5", "4th row", done_log.size() > 3 ? done_log[3] & 255 : -1, 31);
    chk("R7", "count", done_log.size(), 4);
    // r2_: saturate the buffer, offers while full are dropped
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      req_valid = 1; req_tid = 2; req_row = 8'(40 + (k % 3)); req_col = 7'(k);
    end
    @(negedge clk);
    req_valid = 0;
    drain();
    // streaming thread interleaved with a random-row thread
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      req_valid = ($urandom_range(0, 3) != 0);
      if (k % 2 == 0) begin
        req_tid = 0; req_row = 8'd3; req_col = 7'(k / 2);
      end else begin
        req_tid = 1; req_row = 8'($urandom_range(0, 15));
        req_col = 7'($urandom_range(0, 127));
      end
    end
    @(negedge clk);
    req_valid = 0;
    drain();
    chk("R8", "drained", mq.size(), 0);
  endtask

  initial begin
    fork
      run_main();
      begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL R7 watchdog actual=hung expected=finish");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule